// File: doc/BRIEF.md
# Multiplexed Bus Address Demultiplexer

This block sits beside a 16-bit bus whose pins carry an address while the bus phase clock E is low and carry data while E is high. A free-running system clock samples E, the read/write line, the active-low lane strobe and the sixteen bus pins. The samples pass through a short synchronizing pipeline. When a rising edge of E is seen in the synchronized stream, the block keeps the last address-phase sample. That sample is made of the address, the strobe and the direction. The block holds it until the next rising edge of E.

From the held strobe and the held address bit 0, the block decodes which byte lanes the current data phase uses. The upper bus byte (bits 15..8) is the even-address lane. The lower bus byte (bits 7..0) is the odd-address lane. The block also reports whether the access is a 16-bit word access or a strobe/A0 combination that is not allowed on the bus. A data-phase-valid output marks the cycles in which the held address and the lane decode belong to an active data phase. Chip-select comparison and the storage of data are left to the logic around the block.

Top module: `abus_demux`

## Requirements
- R1: While reset is high and after it, until the first rising edge of E, every output is 0: `addr_q`, `xfer_read`, `phase_valid`, `even_en`, `odd_en`, `wide_acc` and `illegal_acc`.
- R2: `phase_valid` equals the level of `bus_e` delayed by SYNC_STAGES+1 clock edges. With the default SYNC_STAGES=2, a level sampled at edge k appears after edge k+2.
- R3: On the cycle a synchronized rising edge of E is detected, `addr_q` takes the bus word from the last sample taken with E low. Bus bits 15..8 become address bits 15..8, and bus bits 7..0 become address bits 7..0.
- R4: `addr_q` does not change at any edge other than a detected rising edge of E. Bus values seen while E is high have no effect on it.
- R5: A held strobe of 0 with a held address bit 0 of 0 is a 16-bit access. During the data phase, `wide_acc`, `even_en` and `odd_en` are 1 and `illegal_acc` is 0.
- R6: A held strobe of 0 with a held address bit 0 of 1 is an 8-bit odd access. During the data phase only `odd_en` is 1.
- R7: A held strobe of 1 with a held address bit 0 of 0 is an 8-bit even access. During the data phase only `even_en` is 1.
- R8: A held strobe of 1 with a held address bit 0 of 1 is illegal. During the data phase `illegal_acc` is 1, and `even_en`, `odd_en` and `wide_acc` are 0.
- R9: While `phase_valid` is 0, `even_en`, `odd_en`, `wide_acc` and `illegal_acc` are all 0.
- R10: `xfer_read` takes the address-phase value of `bus_rd` (1 = read) together with the address. Changes of `bus_rd` or `bus_lstb_n` while E is high do not alter `xfer_read` or the lane decode until the next rising edge of E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| bus_e | input | 1 | Bus phase clock: low for address, high for data |
| bus_rd | input | 1 | Transfer direction, 1 = read |
| bus_lstb_n | input | 1 | Active-low lower (odd) byte strobe |
| bus_ad | input | 16 | Multiplexed address/data pins |
| addr_q | output | 16 | Held address of the current or last transfer |
| xfer_read | output | 1 | Held direction of the transfer |
| phase_valid | output | 1 | Synchronized data phase is active |
| even_en | output | 1 | Even (upper) byte lane in use |
| odd_en | output | 1 | Odd (lower) byte lane in use |
| wide_acc | output | 1 | 16-bit word access |
| illegal_acc | output | 1 | Strobe/A0 combination not allowed |

## Verification
The hardest case to reach from the ports is the tightest timing. In it, E stays low for a single system-clock sample, so exactly one address sample is available to capture. It may also stay high for a single sample, so the data phase is one cycle long. At the same time the direction and strobe lines are flipped during the data phase. The stimulus reaches this case by generating bus cycles with phase lengths chosen at random from one to four clocks. It flips the strobe, the direction and the bus word on every data phase. A behavioural reference model checks the held address and the lane outputs on every clock.

// File: rtl/abus_pkg.sv
package abus_pkg;

    localparam int BUS_W = 16;

    typedef logic [BUS_W-1:0] bus_word_t;

    // One sample of the bus pins taken on the system clock
    typedef struct packed {
        logic      e;
        logic      rd;
        logic      lstb_n;
        bus_word_t ad;
    } bus_sample_t;

    localparam bus_sample_t IDLE_SAMPLE = '{e: 1'b0, rd: 1'b0, lstb_n: 1'b1, ad: '0};

    typedef enum logic [1:0] {
        ACC_WIDE = 2'd0,
        ACC_ODD  = 2'd1,
        ACC_EVEN = 2'd2,
        ACC_BAD  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic even;
        logic odd;
        logic wide;
        logic bad;
    } lane_set_t;

    localparam lane_set_t NO_LANES = '{even: 1'b0, odd: 1'b0, wide: 1'b0, bad: 1'b0};

    function automatic acc_kind_e classify(input logic lstb_n, input logic a0);
        acc_kind_e k;
        case ({lstb_n, a0})
            2'b00:   k = ACC_WIDE;
            2'b01:   k = ACC_ODD;
            2'b10:   k = ACC_EVEN;
            default: k = ACC_BAD;
        endcase
        return k;
    endfunction

    function automatic lane_set_t lanes_for(input acc_kind_e k);
        lane_set_t l;
        l = NO_LANES;
        case (k)
            ACC_WIDE: begin l.even = 1'b1; l.odd = 1'b1; l.wide = 1'b1; end
            ACC_ODD:  l.odd  = 1'b1;
            ACC_EVEN: l.even = 1'b1;
            default:  l.bad  = 1'b1;
        endcase
        return l;
    endfunction

endpackage

// File: rtl/abus_input_pipe.sv
module abus_input_pipe
    import abus_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  bus_sample_t raw,
    output logic        e_now,
    output logic        e_rise,
    output bus_word_t   last_ad,
    output logic        last_rd,
    output logic        last_lstb_n
);
    localparam int DEPTH = STAGES + 1;

    bus_sample_t [DEPTH-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) pipe[i] <= IDLE_SAMPLE;
        end else begin
            pipe[0] <= raw;
            for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
        end
    end

    // Stage STAGES-1 is the synchronized present, stage STAGES the sample before it
    assign e_now       = pipe[STAGES-1].e;
    assign e_rise      = pipe[STAGES-1].e & ~pipe[STAGES].e;
    assign last_ad     = pipe[STAGES].ad;
    assign last_rd     = pipe[STAGES].rd;
    assign last_lstb_n = pipe[STAGES].lstb_n;

endmodule

// File: rtl/abus_addr_capture.sv
module abus_addr_capture
    import abus_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      e_now,
    input  logic      e_rise,
    input  bus_word_t last_ad,
    input  logic      last_rd,
    input  logic      last_lstb_n,
    output bus_word_t addr_q,
    output logic      rd_q,
    output logic      lstb_n_q,
    output logic      phase_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q   <= '0;
            rd_q     <= 1'b0;
            lstb_n_q <= 1'b1;
            phase_q  <= 1'b0;
        end else begin
            phase_q <= e_now;
            if (e_rise) begin
                addr_q   <= last_ad;
                rd_q     <= last_rd;
                lstb_n_q <= last_lstb_n;
            end
        end
    end

    assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
        e_rise |=> addr_q == $past(last_ad));

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !e_rise |=> $stable(addr_q));

    assert_ctrl_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !e_rise |=> ($stable(rd_q) && $stable(lstb_n_q)));

endmodule

// File: rtl/abus_lane_decode.sv
module abus_lane_decode
    import abus_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic phase,
    input  logic lstb_n,
    input  logic a0,
    output logic even_en,
    output logic odd_en,
    output logic wide_acc,
    output logic illegal_acc
);
    acc_kind_e kind;
    lane_set_t lanes;

    always_comb begin
        kind  = classify(lstb_n, a0);
        lanes = phase ? lanes_for(kind) : NO_LANES;
    end

    assign even_en     = lanes.even;
    assign odd_en      = lanes.odd;
    assign wide_acc    = lanes.wide;
    assign illegal_acc = lanes.bad;

    assert_wide_both_R5: assert property (@(posedge clk) disable iff (rst)
        wide_acc |-> (even_en && odd_en && !a0 && !lstb_n));

    assert_odd_only_R6: assert property (@(posedge clk) disable iff (rst)
        (odd_en && !even_en) |-> (a0 && !lstb_n));

    assert_even_only_R7: assert property (@(posedge clk) disable iff (rst)
        (even_en && !odd_en) |-> (!a0 && lstb_n));

    assert_illegal_no_lane_R8: assert property (@(posedge clk) disable iff (rst)
        illegal_acc |-> (!even_en && !odd_en && !wide_acc));

    assert_gated_R9: assert property (@(posedge clk) disable iff (rst)
        !phase |-> $countones({even_en, odd_en, wide_acc, illegal_acc}) == 0);

endmodule

// File: rtl/abus_demux.sv
module abus_demux
    import abus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_e,
    input  logic        bus_rd,
    input  logic        bus_lstb_n,
    input  logic [15:0] bus_ad,
    output logic [15:0] addr_q,
    output logic        xfer_read,
    output logic        phase_valid,
    output logic        even_en,
    output logic        odd_en,
    output logic        wide_acc,
    output logic        illegal_acc
);
    bus_sample_t raw;
    logic        e_now;
    logic        e_rise;
    bus_word_t   last_ad;
    logic        last_rd;
    logic        last_lstb_n;
    logic        lstb_n_q;

    assign raw = '{e: bus_e, rd: bus_rd, lstb_n: bus_lstb_n, ad: bus_ad};

    abus_input_pipe #(.STAGES(SYNC_STAGES)) u_pipe (
        .clk         (clk),
        .rst         (rst),
        .raw         (raw),
        .e_now       (e_now),
        .e_rise      (e_rise),
        .last_ad     (last_ad),
        .last_rd     (last_rd),
        .last_lstb_n (last_lstb_n)
    );

    abus_addr_capture u_capture (
        .clk         (clk),
        .rst         (rst),
        .e_now       (e_now),
        .e_rise      (e_rise),
        .last_ad     (last_ad),
        .last_rd     (last_rd),
        .last_lstb_n (last_lstb_n),
        .addr_q      (addr_q),
        .rd_q        (xfer_read),
        .lstb_n_q    (lstb_n_q),
        .phase_q     (phase_valid)
    );

    abus_lane_decode u_decode (
        .clk         (clk),
        .rst         (rst),
        .phase       (phase_valid),
        .lstb_n      (lstb_n_q),
        .a0          (addr_q[0]),
        .even_en     (even_en),
        .odd_en      (odd_en),
        .wide_acc    (wide_acc),
        .illegal_acc (illegal_acc)
    );

    assert_phase_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(phase_valid) |-> $past(e_rise));

endmodule

// File: tb/test_abus_demux.sv
module test_abus_demux;

    localparam int ST = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_e = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_lstb_n = 1'b1;
    logic [15:0] bus_ad = 16'h0;
    logic [15:0] addr_q;
    logic        xfer_read, phase_valid, even_en, odd_en, wide_acc, illegal_acc;

    always #2 clk = ~clk;

    abus_demux #(.SYNC_STAGES(ST)) i_abus_demux (
        .clk(clk), .rst(rst), .bus_e(bus_e), .bus_rd(bus_rd),
        .bus_lstb_n(bus_lstb_n), .bus_ad(bus_ad), .addr_q(addr_q),
        .xfer_read(xfer_read), .phase_valid(phase_valid), .even_en(even_en),
        .odd_en(odd_en), .wide_acc(wide_acc), .illegal_acc(illegal_acc)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    // Reference model: history of what the bench drove, and the expected held state
    logic        h_e [0:ST];
    logic        h_rd [0:ST];
    logic        h_lb [0:ST];
    logic [15:0] h_ad [0:ST];
    logic [15:0] m_addr = 16'h0;
    logic        m_rd = 1'b0;
    logic        m_lb = 1'b1;
    logic        m_ph = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i <= ST; i++) begin
                h_e[i] = 1'b0; h_rd[i] = 1'b0; h_lb[i] = 1'b1; h_ad[i] = 16'h0;
            end
            m_addr = 16'h0; m_rd = 1'b0; m_lb = 1'b1; m_ph = 1'b0;
        end else begin
            if (h_e[ST-1] && !h_e[ST]) begin
                m_addr = h_ad[ST]; m_rd = h_rd[ST]; m_lb = h_lb[ST];
            end
            m_ph = h_e[ST-1];
            for (int i = ST; i > 0; i--) begin
                h_e[i] = h_e[i-1]; h_rd[i] = h_rd[i-1]; h_lb[i] = h_lb[i-1]; h_ad[i] = h_ad[i-1];
            end
            h_e[0] = bus_e; h_rd[0] = bus_rd; h_lb[0] = bus_lstb_n; h_ad[0] = bus_ad;
        end
    end

    task automatic check(input logic [15:0] act, input logic [15:0] exp,
                         input string req, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge
    bit compare_on = 1'b0;
    always @(negedge clk) begin
        if (compare_on) begin
            logic ee, oo, ww, bb;
            string lreq;
            ee = 1'b0; oo = 1'b0; ww = 1'b0; bb = 1'b0;
            case ({m_lb, m_addr[0]})
                2'b00: begin ee = 1'b1; oo = 1'b1; ww = 1'b1; lreq = "R5"; end
                2'b01: begin oo = 1'b1; lreq = "R6"; end
                2'b10: begin ee = 1'b1; lreq = "R7"; end
                default: begin bb = 1'b1; lreq = "R8"; end
            endcase
            if (!m_ph) begin
                ee = 1'b0; oo = 1'b0; ww = 1'b0; bb = 1'b0; lreq = "R9";
            end
            check(addr_q, m_addr, "R3/R4", "addr_q");
            check({15'h0, phase_valid}, {15'h0, m_ph}, "R2", "phase_valid");
            check({15'h0, xfer_read}, {15'h0, m_rd}, "R10", "xfer_read");
            check({12'h0, even_en, odd_en, wide_acc, illegal_acc},
                  {12'h0, ee, oo, ww, bb}, lreq, "lanes");
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One bus cycle: address phase of lo clocks, data phase of hi clocks.
    // During the data phase the direction and strobe lines are flipped (R10, R4).
    task automatic bus_cycle(input logic [15:0] a, input logic rd, input logic lb,
                             input logic [15:0] d, input int lo, input int hi);
        @(negedge clk); #1;
        bus_e = 1'b0; bus_ad = a; bus_rd = rd; bus_lstb_n = lb;
        for (int i = 1; i < lo; i++) @(negedge clk);
        @(negedge clk); #1;
        bus_e = 1'b1; bus_ad = d; bus_rd = ~rd; bus_lstb_n = ~lb;
        for (int i = 1; i < hi; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
            finish_run();
        end
    end

    initial begin
        idle(4);
        // R1: reset state
        check({addr_q[15:0]}, 16'h0, "R1", "addr_q in reset");
        check({9'h0, xfer_read, phase_valid, even_en, odd_en, wide_acc, illegal_acc, 1'b0},
              16'h0, "R1", "flags in reset");
        #1 rst = 1'b0;
        compare_on = 1'b1;
        idle(3);
        check(addr_q, 16'h0, "R1", "addr_q before first E");

        // Directed: the four strobe/A0 combinations (R5..R8)
        bus_cycle(16'h4000, 1'b1, 1'b0, 16'hA55A, 2, 3);
        bus_cycle(16'h4001, 1'b0, 1'b0, 16'h1234, 2, 3);
        bus_cycle(16'h4000, 1'b1, 1'b1, 16'hFFFF, 2, 3);
        bus_cycle(16'h4001, 1'b1, 1'b1, 16'h0000, 2, 3);
        // Byte placement (R3): distinct upper and lower bytes
        bus_cycle(16'hC37E, 1'b0, 1'b0, 16'h3C81, 3, 4);
        // Long idle address phase with changing bus: held address must stay (R4)
        @(negedge clk); #1; bus_e = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); #1; bus_ad = bus_ad + 16'h1111;
        end
        // Tightest timing: one-sample phases
        bus_cycle(16'h8001, 1'b1, 1'b0, 16'hDEAD, 1, 1);
        bus_cycle(16'h7FFE, 1'b0, 1'b1, 16'hBEEF, 1, 1);
        // Random cycles with random phase lengths
        for (int n = 0; n < 300; n++) begin
            bus_cycle(16'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
                      int'($urandom_range(1, 4)), int'($urandom_range(1, 4)));
        end
        @(negedge clk); #1; bus_e = 1'b0;
        idle(6);
        // Reset in the middle of a data phase returns everything to 0 (R1)
        bus_cycle(16'h5555, 1'b1, 1'b0, 16'h0F0F, 2, 4);
        compare_on = 1'b0;
        @(negedge clk); #1; rst = 1'b1;
        idle(2);
        check(addr_q, 16'h0, "R1", "addr_q after mid-phase reset");
        check({12'h0, even_en, odd_en, phase_valid, xfer_read}, 16'h0, "R1", "flags after mid-phase reset");
        #1 rst = 1'b0; bus_e = 1'b0;
        idle(1);
        compare_on = 1'b1;
        idle(4);
        finish_run();
    end

endmodule